// File: doc/BRIEF.md
# Pin Function and Pad Pull Controller

This block holds the configuration of one bank of pins. For each pin it selects whether the general-purpose I/O logic or a peripheral drives the pin. When a peripheral drives it, the block also selects which of four peripheral functions is used. It also sets the per-pin pad controls: pull-up, pull-down, open-drain drive and Schmitt-trigger disable. Software configures the block through a narrow word-addressed bus. Each write takes effect at one clock edge. Reads are combinational on the address.

Ownership, pull-up, pull-down and open-drain each use a pair of write-only registers, one that sets bits and one that clears them. A write of 1 acts on that pin and a write of 0 leaves it alone. A read-only status register shows the current state of each pair. The two function-select registers and the Schmitt register are plain read/write registers. Software changes one pin in them with a read-modify-write. Pull-up and pull-down are kept mutually exclusive inside the block. Writes arrive one per cycle, so the most recent pull write always decides the result.

Top module: `pin_func_ctrl`

## Requirements
- R1: Reset state:
  - every pin is owned by GPIO (`gpio_own` all ones);
  - all function selects are 00;
  - all pull-ups are on;
  - pull-down, open-drain and Schmitt disable are all zero.
- R2: `func_sel[2i+1:2i]` is `{select_hi[i], select_lo[i]}`. This gives function A=00, B=01, C=10 and D=11.
- R3: Address 3 (select_lo), address 4 (select_hi) and address 14 (Schmitt) are plain read/write registers. A write replaces the whole word, and a read returns it.
- R4: Ownership pair:
  - a write to address 1 clears `gpio_own` for each 1 bit, handing those pins to the peripheral;
  - a write to address 0 sets `gpio_own` for each 1 bit;
  - 0 bits leave the pin unchanged;
  - address 2 reads `gpio_own`.
- R5: Pull-up pair:
  - address 5 turns pull-ups on for the 1 bits;
  - address 6 turns them off for the 1 bits;
  - 0 bits have no effect;
  - address 7 reads the pull-up state.
- R6: Pull-down pair:
  - address 8 turns pull-downs on for the 1 bits and turns pull-ups off for the same pins;
  - address 9 turns pull-downs off;
  - address 10 reads the pull-down state;
  - a pull-up enable at address 5 turns pull-down off for its pins;
  - `pull_up & pull_dn` is never nonzero.
- R7: Open-drain pair:
  - address 11 sets `open_drain` for the 1 bits;
  - address 12 clears them;
  - address 13 reads the state.
- R8: A 1 in the Schmitt register drives `schmitt_off` high for that pin.
- R9: Addresses 0, 1, 5, 6, 8, 9, 11, 12 and 15 read as zero. A write to address 15 changes no state.
- R10: `bus_rdata` follows `bus_addr` and the current state in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data for `bus_addr` |
| func_sel | output | 2*NPINS | Per-pin 2-bit peripheral function code |
| gpio_own | output | NPINS | 1 = pin owned by GPIO logic |
| pull_up | output | NPINS | Pull-up enable per pin |
| pull_dn | output | NPINS | Pull-down enable per pin |
| open_drain | output | NPINS | Open-drain drive enable per pin |
| schmitt_off | output | NPINS | Schmitt trigger disabled per pin |

## Verification
The hardest case is a pin whose pull-up and pull-down enables are requested close together. The stimulus must reach states where some pins have pull-down on and others pull-up on. Enables of each kind must then arrive back to back on overlapping and disjoint masks. A long stretch of random writes over all sixteen addresses does this, with random masks and repeated targets. The behavioural model in the bench is compared every clock, so any cycle in which both pulls are on, or an unrelated pin moves, is caught.

// File: rtl/pin_func_ctrl.sv
module pin_func_ctrl #(
  parameter int NPINS = 32,
  parameter int AW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [NPINS-1:0]   bus_wdata,
  output logic [NPINS-1:0]   bus_rdata,
  output logic [2*NPINS-1:0] func_sel,
  output logic [NPINS-1:0]   gpio_own,
  output logic [NPINS-1:0]   pull_up,
  output logic [NPINS-1:0]   pull_dn,
  output logic [NPINS-1:0]   open_drain,
  output logic [NPINS-1:0]   schmitt_off
);
  localparam logic [AW-1:0] A_OWN_GPIO = AW'(0);
  localparam logic [AW-1:0] A_OWN_PER  = AW'(1);
  localparam logic [AW-1:0] A_OWN_STAT = AW'(2);
  localparam logic [AW-1:0] A_SEL_LO   = AW'(3);
  localparam logic [AW-1:0] A_SEL_HI   = AW'(4);
  localparam logic [AW-1:0] A_PU_ON    = AW'(5);
  localparam logic [AW-1:0] A_PU_OFF   = AW'(6);
  localparam logic [AW-1:0] A_PU_STAT  = AW'(7);
  localparam logic [AW-1:0] A_PD_ON    = AW'(8);
  localparam logic [AW-1:0] A_PD_OFF   = AW'(9);
  localparam logic [AW-1:0] A_PD_STAT  = AW'(10);
  localparam logic [AW-1:0] A_OD_ON    = AW'(11);
  localparam logic [AW-1:0] A_OD_OFF   = AW'(12);
  localparam logic [AW-1:0] A_OD_STAT  = AW'(13);
  localparam logic [AW-1:0] A_SCHMITT  = AW'(14);
  localparam logic [AW-1:0] A_LAST     = AW'(14);

  logic [NPINS-1:0] own_q, sel_lo_q, sel_hi_q, pu_q, pd_q, od_q, st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= '1;
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      pu_q     <= '1;
      pd_q     <= '0;
      od_q     <= '0;
      st_q     <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OWN_GPIO: own_q    <= own_q | bus_wdata;
        A_OWN_PER:  own_q    <= own_q & ~bus_wdata;
        A_SEL_LO:   sel_lo_q <= bus_wdata;
        A_SEL_HI:   sel_hi_q <= bus_wdata;
        A_PU_ON: begin
          pu_q <= pu_q | bus_wdata;
          pd_q <= pd_q & ~bus_wdata;
        end
        A_PU_OFF:   pu_q     <= pu_q & ~bus_wdata;
        A_PD_ON: begin
          pd_q <= pd_q | bus_wdata;
          pu_q <= pu_q & ~bus_wdata;
        end
        A_PD_OFF:   pd_q     <= pd_q & ~bus_wdata;
        A_OD_ON:    od_q     <= od_q | bus_wdata;
        A_OD_OFF:   od_q     <= od_q & ~bus_wdata;
        A_SCHMITT:  st_q     <= bus_wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_sel
    assign func_sel[2*i +: 2] = {sel_hi_q[i], sel_lo_q[i]};
  end

  assign gpio_own    = own_q;
  assign pull_up     = pu_q;
  assign pull_dn     = pd_q;
  assign open_drain  = od_q;
  assign schmitt_off = st_q;

  always_comb begin
    case (bus_addr)
      A_OWN_STAT: bus_rdata = own_q;
      A_SEL_LO:   bus_rdata = sel_lo_q;
      A_SEL_HI:   bus_rdata = sel_hi_q;
      A_PU_STAT:  bus_rdata = pu_q;
      A_PD_STAT:  bus_rdata = pd_q;
      A_OD_STAT:  bus_rdata = od_q;
      A_SCHMITT:  bus_rdata = st_q;
      default:    bus_rdata = '0;
    endcase
  end

  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & pull_dn) == '0); // R6

  AST_PD_DROPS_PU: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PD_ON) |=> (pull_up & $past(bus_wdata)) == '0); // R6

  AST_PERIPH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OWN_PER) |=> (gpio_own & $past(bus_wdata)) == '0); // R4

  AST_OWN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OWN_PER) |=>
      (gpio_own & ~$past(bus_wdata)) == ($past(gpio_own) & ~$past(bus_wdata))); // R4

  AST_PU_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PU_ON) |=> (pull_up & $past(bus_wdata)) == $past(bus_wdata)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we || bus_addr > A_LAST) |=>
      ($stable(gpio_own) && $stable(func_sel) && $stable(pull_up) &&
       $stable(pull_dn) && $stable(open_drain) && $stable(schmitt_off))); // R9
endmodule

// File: tb/sim_pin_func_ctrl.sv
module sim_pin_func_ctrl;
  localparam int N = 32;
  logic clk = 0, rst_n = 0, we = 0;
  logic [3:0] addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, own, pu, pd, od, st;
  logic [2*N-1:0] fsel;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit live = 0;

  logic [N-1:0] m_own, m_lo, m_hi, m_pu, m_pd, m_od, m_st;

  pin_func_ctrl #(.NPINS(N), .AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .func_sel(fsel), .gpio_own(own), .pull_up(pu),
    .pull_dn(pd), .open_drain(od), .schmitt_off(st));

  always #2 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] mread(logic [3:0] a);
    case (a)
      4'd2:  return m_own;
      4'd3:  return m_lo;
      4'd4:  return m_hi;
      4'd7:  return m_pu;
      4'd10: return m_pd;
      4'd13: return m_od;
      4'd14: return m_st;
      default: return '0;
    endcase
  endfunction

  function automatic logic [2*N-1:0] mfsel();
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[2*i]   = m_lo[i];
      r[2*i+1] = m_hi[i];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = '1; m_lo = '0; m_hi = '0; m_pu = '1; m_pd = '0; m_od = '0; m_st = '0;
      live = 1;
    end else if (we) begin
      if (addr == 0) m_own = m_own | wdata;
      if (addr == 1) m_own = m_own & ~wdata;
      if (addr == 3) m_lo = wdata;
      if (addr == 4) m_hi = wdata;
      if (addr == 5) begin m_pu = m_pu | wdata; m_pd = m_pd & ~wdata; end
      if (addr == 6) m_pu = m_pu & ~wdata;
      if (addr == 8) begin m_pd = m_pd | wdata; m_pu = m_pu & ~wdata; end
      if (addr == 9) m_pd = m_pd & ~wdata;
      if (addr == 11) m_od = m_od | wdata;
      if (addr == 12) m_od = m_od & ~wdata;
      if (addr == 14) m_st = wdata;
    end
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (live && rst_n) begin
      check("R2 func_sel", fsel, mfsel());
      check("R4 gpio_own", 64'(own), 64'(m_own));
      check("R5 pull_up", 64'(pu), 64'(m_pu));
      check("R6 pull_dn", 64'(pd), 64'(m_pd));
      check("R6 exclusive", 64'(pu & pd), 64'd0);
      check("R7 open_drain", 64'(od), 64'(m_od));
      check("R8 schmitt_off", 64'(st), 64'(m_st));
      check("R10 rdata", 64'(rdata), 64'(mread(addr)));
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [N-1:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    check(tag, 64'(rdata), 64'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 own", 64'(own), 64'hFFFF_FFFF);
    check("R1 sel", fsel, 64'd0);
    check("R1 pu", 64'(pu), 64'hFFFF_FFFF);
    check("R1 pd/od/st", 64'(pd | od | st), 64'd0);
    rd(4'd2, '1, "R1 own stat");

    wr(4'd3, 32'hA5A5_0F0F);
    wr(4'd4, 32'h3C3C_00FF);
    rd(4'd3, 32'hA5A5_0F0F, "R3 sel_lo readback");
    rd(4'd4, 32'h3C3C_00FF, "R3 sel_hi readback");
    @(negedge clk); #1;
    check("R2 pin0 D", 64'(fsel[1:0]), 64'd3);
    check("R2 pin4 C", 64'(fsel[9:8]), 64'd2);
    check("R2 pin16 B", 64'(fsel[33:32]), 64'd1);
    check("R2 pin17 A", 64'(fsel[35:34]), 64'd0);

    wr(4'd1, 32'h0000_00F0);
    rd(4'd2, 32'hFFFF_FF0F, "R4 periph take");
    wr(4'd1, 32'h0);
    rd(4'd2, 32'hFFFF_FF0F, "R4 zero no effect");
    wr(4'd0, 32'h0000_0030);
    rd(4'd2, 32'hFFFF_FF3F, "R4 gpio return");

    wr(4'd6, 32'h0000_FFFF);
    rd(4'd7, 32'hFFFF_0000, "R5 pu off");
    wr(4'd5, 32'h0000_000F);
    rd(4'd7, 32'hFFFF_000F, "R5 pu on");

    wr(4'd8, 32'h00FF_00FF);
    rd(4'd10, 32'h00FF_00FF, "R6 pd on");
    rd(4'd7, 32'hFF00_0000, "R6 pd clears pu");
    wr(4'd5, 32'h0000_0003);
    rd(4'd10, 32'h00FF_00FC, "R6 pu clears pd");
    wr(4'd9, 32'h00FF_0000);
    rd(4'd10, 32'h0000_00FC, "R6 pd off");

    wr(4'd11, 32'hF000_000F);
    wr(4'd12, 32'h1000_0001);
    rd(4'd13, 32'hE000_000E, "R7 od pair");

    wr(4'd14, 32'h8000_0001);
    rd(4'd14, 32'h8000_0001, "R3 schmitt readback");
    @(negedge clk); #1;
    check("R8 schmitt_off", 64'(st), 64'h8000_0001);

    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd15, 32'h0, "R9 unmapped read");
    rd(4'd2, 32'hFFFF_FF3F, "R9 unmapped write ignored");
    rd(4'd5, 32'h0, "R9 write-only read");
    rd(4'd1, 32'h0, "R9 write-only read");

    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      we = ($urandom % 4) != 0;
      addr = 4'($urandom);
      case ($urandom % 3)
        0: wdata = $urandom;
        1: wdata = N'(1) << ($urandom % N);
        default: wdata = $urandom & $urandom;
      endcase
    end
    @(negedge clk); we = 0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule